// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Collector with Input Change Detection

This block gathers the interrupt requests of a two-channel serial controller into one status byte. It also watches four general input pins for changes. Seven level-sensitive sources arrive on `chan_src`: transmit ready, receive ready and break change for each channel, plus the counter-ready flag. They occupy status bits 6:0. Bit 7 of the status byte reports that at least one watched pin has changed, counting only the pins whose change enable is set.

A mask byte selects which status bits may raise the single active-high `irq` output. `irq` is registered. Seven general inputs are synchronized into the clock domain. The lowest four of them drive per-pin change flags, which are set by a rising or a falling edge. Software reads the pin levels and the change flags together from one register, and that read clears the flags.

Software reaches the block through a small byte bus. Reads return data in the same cycle as `bus_rd`. Writes and read side effects take effect at the clock edge that ends the access.

Top module: `irq_hub`

## Requirements
- R1: A read at address 5 returns the status byte. Bits 6:0 equal `chan_src[6:0]` in the same cycle: bit 0 transmit ready A, bit 1 receive ready A, bit 2 break change A, bit 3 counter ready, bits 4 to 6 the same three sources for channel B. Bit 7 is the input-change summary.
- R2: A write at address 5 loads the 8-bit mask, with bit positions matching the status byte. `irq` equals the OR of (status AND mask) as it was one clock earlier.
- R3: A read at address 4 returns the change register: the synchronized levels of pins 0 to 3 in bits 3:0 and their change flags in bits 7:4.
- R4: A new level on `gp_in` appears in the read-back levels after two rising clock edges.
- R5: Both a rising and a falling edge on watched pin i set change flag i. The flag is visible three rising edges after the pin changes.
- R6: A read at address 4 clears all change flags at the edge that ends it. If a pin edge is detected at that same edge, its flag stays set.
- R7: A write at address 4 loads the change enables from `bus_wdata[3:0]`, one bit per pin. Status bit 7 is 1 exactly when some change flag is set and its enable bit is 1.
- R8: A read at address 13 returns bit 7 as 1 and the synchronized levels of `gp_in[6:0]` in bits 6:0.
- R9: After reset, the mask, the change enables and the change flags are 0 and `irq` is 0. No change flag is set during the first three edges after reset.
- R10: A read at any other address, and any cycle without `bus_rd`, returns 0. A write at any other address changes neither the mask nor the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| chan_src | input | 7 | Level interrupt sources, status order |
| gp_in | input | 7 | Asynchronous general inputs |
| irq | output | 1 | Active-high interrupt request |

## Verification
Read data depends only on the current bus inputs and the state. The bench therefore compares `bus_rdata` in the same cycle, at the falling edge. `irq` trails its cause by one rising edge, so the reference model moves its expected `irq` forward only at the rising edge. Pin levels are due two edges after a pin change and change flags three edges after it. The directed checks count exactly those edges before they look, and one of them puts a clearing read on the very edge that detects an edge, to test the tie in R6.

// File: rtl/irq_pkg.sv
// Package irq_pkg
// Shared widths, register addresses and the address decoder of the
// interrupt collector. Assumes a byte-wide register file with 16 addresses.
package irq_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 4;
    localparam int N_SRC    = DATA_W - 1;
    localparam int N_GP     = 7;
    localparam int N_WATCH  = 4;

    localparam logic [ADDR_W-1:0] ADR_CHANGE = 4'd4;
    localparam logic [ADDR_W-1:0] ADR_STATUS = 4'd5;
    localparam logic [ADDR_W-1:0] ADR_PORT   = 4'd13;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_CHANGE = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_PORT   = 2'd3
    } reg_sel_e;

    // Map a bus address onto the register it selects.
    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        unique case (a)
            ADR_CHANGE: s = SEL_CHANGE;
            ADR_STATUS: s = SEL_STATUS;
            ADR_PORT:   s = SEL_PORT;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/irq_pin_sync.sv
// Module irq_pin_sync
// Brings N asynchronous pins into the clock domain through STAGES flops,
// and keeps one more flop of history for edge detection on the lowest
// N_EDGE pins. Edges are suppressed until the whole chain holds real
// samples taken after reset, so that a high pin at reset release is not
// mistaken for a change.
module irq_pin_sync #(
    parameter int N      = 7,
    parameter int N_EDGE = 4,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      pin_i,
    output logic [N-1:0]      lvl_o,
    output logic [N_EDGE-1:0] edge_o
);

    localparam int DEPTH   = STAGES + 1;
    localparam int CNT_W   = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [CNT_W-1:0] fill_q;
    logic             warm;

    // Count edges since reset until the chain is filled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fill_q <= '0;
        else if (fill_q != CNT_FULL)
            fill_q <= fill_q + CNT_W'(1);
    end

    assign warm = (fill_q == CNT_FULL);

    for (genvar g = 0; g < N; g++) begin : g_pin
        logic [DEPTH-1:0] chain_q;

        // Shift the pin sample through the synchronizer and history flops.
        always_ff @(posedge clk) begin
            if (!rst_n)
                chain_q <= '0;
            else
                chain_q <= {chain_q[DEPTH-2:0], pin_i[g]};
        end

        assign lvl_o[g] = chain_q[STAGES-1];

        if (g < N_EDGE) begin : g_edge
            assign edge_o[g] = warm & (chain_q[STAGES-1] ^ chain_q[STAGES]);
        end
    end

endmodule

// File: rtl/irq_delta_bank.sv
// Module irq_delta_bank
// Holds one sticky change flag per watched pin. A detected edge sets its
// flag; a clear strobe drops all flags, but an edge in the same cycle
// wins so no change is lost.
module irq_delta_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] edge_i,
    input  logic         clr_i,
    output logic [N-1:0] flag_o
);

    logic [N-1:0] flag_q;

    // Set on edge, clear on strobe, set takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= '0;
        else
            flag_q <= (clr_i ? '0 : flag_q) | edge_i;
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/irq_regfile.sv
// Module irq_regfile
// Byte-bus register file: holds the interrupt mask and the per-pin change
// enables, multiplexes the read data, and flags a read of the change
// register so the flags can be cleared. Assumes single-cycle strobes.
module irq_regfile
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] status_i,
    input  logic [N_GP-1:0]   lvl_i,
    input  logic [N_WATCH-1:0] flag_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] mask_o,
    output logic [N_WATCH-1:0] en_o,
    output logic              chg_clr_o
);

    localparam int PAD_W = DATA_W - N_GP;

    reg_sel_e            sel;
    logic [DATA_W-1:0]   mask_q;
    logic [N_WATCH-1:0]  en_q;

    assign sel = decode_addr(addr_i);

    // Load the mask and the change enables on writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            en_q   <= '0;
        end else if (wr_i) begin
            if (sel == SEL_STATUS) mask_q <= wdata_i;
            if (sel == SEL_CHANGE) en_q   <= wdata_i[N_WATCH-1:0];
        end
    end

    // Select read data; zero when idle or unmapped.
    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            unique case (sel)
                SEL_CHANGE: rdata_o = {flag_i, lvl_i[N_WATCH-1:0]};
                SEL_STATUS: rdata_o = status_i;
                SEL_PORT:   rdata_o = {{PAD_W{1'b1}}, lvl_i};
                default:    rdata_o = '0;
            endcase
        end
    end

    assign chg_clr_o = rd_i && (sel == SEL_CHANGE);
    assign mask_o    = mask_q;
    assign en_o      = en_q;

endmodule

// File: rtl/irq_hub.sv
// Module irq_hub
// Top of the interrupt collector: assembles the status byte from the
// channel sources and the enabled change flags, and registers the masked
// OR as the interrupt request. Assumes level sources already in this
// clock domain and asynchronous general inputs.
module irq_hub
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [6:0]        chan_src,
    input  logic [6:0]        gp_in,
    output logic              irq
);

    logic [N_GP-1:0]    lvl;
    logic [N_WATCH-1:0] pin_edge;
    logic [N_WATCH-1:0] delta_q;
    logic [N_WATCH-1:0] chg_en;
    logic [DATA_W-1:0]  mask;
    logic [DATA_W-1:0]  status;
    logic               chg_clr;
    logic               irq_q;

    irq_pin_sync #(.N(N_GP), .N_EDGE(N_WATCH), .STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (gp_in),
        .lvl_o  (lvl),
        .edge_o (pin_edge)
    );

    irq_delta_bank #(.N(N_WATCH)) u_delta (
        .clk    (clk),
        .rst_n  (rst_n),
        .edge_i (pin_edge),
        .clr_i  (chg_clr),
        .flag_o (delta_q)
    );

    irq_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_i      (bus_rd),
        .wr_i      (bus_wr),
        .addr_i    (bus_addr),
        .wdata_i   (bus_wdata),
        .status_i  (status),
        .lvl_i     (lvl),
        .flag_i    (delta_q),
        .rdata_o   (bus_rdata),
        .mask_o    (mask),
        .en_o      (chg_en),
        .chg_clr_o (chg_clr)
    );

    // Status byte: channel sources below, enabled change summary on top.
    always_comb begin
        status = {|(delta_q & chg_en), chan_src};
    end

    // Register the masked interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= |(status & mask);
    end

    assign irq = irq_q;

endmodule

// File: rtl/irq_hub_chk.sv
// Module irq_hub_chk
// Property checker for irq_hub, bound to every instance of the top.
module irq_hub_chk
    import irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] status,
    input logic [DATA_W-1:0] mask,
    input logic [N_WATCH-1:0] pin_edge,
    input logic [N_WATCH-1:0] delta_q,
    input logic              chg_clr,
    input logic              irq
);

    assert_irq_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> irq == $past(|(status & mask)));

    assert_edge_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|pin_edge) |=> ((delta_q & $past(pin_edge)) == $past(pin_edge)));

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_clr && pin_edge == '0) |=> delta_q == '0);

    assert_no_flag_no_summary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (delta_q == '0) |-> !status[DATA_W-1]);

    assert_port_top_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADR_PORT) |-> bus_rdata[DATA_W-1]);

    assert_mask_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADR_STATUS) |=> $stable(mask));

    assert_idle_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == '0);

endmodule

bind irq_hub irq_hub_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .status    (status),
    .mask      (mask),
    .pin_edge  (pin_edge),
    .delta_q   (delta_q),
    .chg_clr   (chg_clr),
    .irq       (irq)
);

// File: tb/sim_irq_hub.sv
// Bench for irq_hub: behavioural reference model compared every cycle,
// plus directed checks on latency and clear/set ordering.
module sim_irq_hub;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [6:0] chan_src = '0;
    logic [6:0] gp_in = '0;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_hub u0 (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .chan_src(chan_src), .gp_in(gp_in), .irq(irq)
    );

    // ---------------- reference model ----------------
    logic [7:0] m_mask;
    logic [3:0] m_en;
    logic [3:0] m_flag;
    logic       m_irq;
    logic [6:0] m_hist[$];
    int         m_pushed;

    function automatic logic [6:0] m_lvl();
        return (m_hist.size() >= 2) ? m_hist[1] : 7'h00;
    endfunction

    function automatic logic [7:0] m_status();
        return {|(m_flag & m_en), chan_src};
    endfunction

    function automatic logic [7:0] m_read(input logic [3:0] a);
        logic [6:0] l = m_lvl();
        if (a == 4'd4)  return {m_flag, l[3:0]};
        if (a == 4'd5)  return m_status();
        if (a == 4'd13) return {1'b1, l};
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        logic       n_irq;
        logic [3:0] edges;
        cyc++;
        if (!rst_n) begin
            m_mask = '0; m_en = '0; m_flag = '0; m_irq = 1'b0;
            m_hist.delete(); m_pushed = 0;
        end else begin
            n_irq = |(m_status() & m_mask);
            edges = (m_pushed >= 3) ? (m_hist[1][3:0] ^ m_hist[2][3:0]) : 4'h0;
            if (bus_rd && bus_addr == 4'd4) m_flag = '0;
            m_flag = m_flag | edges;
            if (bus_wr && bus_addr == 4'd5) m_mask = bus_wdata;
            if (bus_wr && bus_addr == 4'd4) m_en = bus_wdata[3:0];
            m_irq = n_irq;
            m_hist.push_front(gp_in);
            if (m_hist.size() > 3) void'(m_hist.pop_back());
            if (m_pushed < 3) m_pushed++;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 irq", {7'h0, irq}, {7'h0, m_irq});
            if (bus_rd) begin
                if (bus_addr == 4'd4)       check("R3 change read", bus_rdata, m_read(bus_addr));
                else if (bus_addr == 4'd5)  check("R1 status read", bus_rdata, m_read(bus_addr));
                else if (bus_addr == 4'd13) check("R8 port read", bus_rdata, m_read(bus_addr));
                else                        check("R10 unmapped read", bus_rdata, 8'h00);
            end else begin
                check("R10 idle read data", bus_rdata, 8'h00);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    task automatic tick(input int n = 1);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        tick();
        bus_rd = 1'b0;
    endtask

    initial begin
        logic [7:0] d;
        tick(4);
        rst_n = 1'b1;
        tick();
        // R9: reset state
        check("R9 irq after reset", {7'h0, irq}, 8'h00);
        rd_reg(4'd4, d); check("R9 flags after reset", d, 8'h00);
        // R1: status layout
        chan_src = 7'h55; #1;
        rd_reg(4'd5, d); check("R1 status mirrors sources", d, 8'h55);
        // R2: mask and registered irq
        wr_reg(4'd5, 8'h01);
        check("R2 irq one edge after mask", {7'h0, irq}, 8'h00);
        tick();
        check("R2 irq raised", {7'h0, irq}, 8'h01);
        wr_reg(4'd5, 8'h02);
        tick();
        check("R2 irq masked off", {7'h0, irq}, 8'h00);
        chan_src = 7'h00;
        // R4/R5/R6: pin 0 rises
        gp_in = 7'h01;
        tick(2);
        bus_rd = 1'b1; bus_addr = 4'd4; #1;
        check("R4 level after two edges", bus_rdata, 8'h01);
        tick();             // clear and edge detection coincide
        bus_rd = 1'b0;
        rd_reg(4'd4, d); check("R6 edge wins over clear", d, 8'h11);
        rd_reg(4'd4, d); check("R6 read cleared flags", d, 8'h01);
        // R7: enable gating on pin 1
        gp_in = 7'h03;
        tick(4);
        rd_reg(4'd5, d); check("R7 disabled pin hides summary", d, 8'h00);
        wr_reg(4'd4, 8'h02);
        rd_reg(4'd5, d); check("R7 enabled pin shows summary", d, 8'h80);
        wr_reg(4'd5, 8'h80);
        tick();
        check("R7 summary drives irq", {7'h0, irq}, 8'h01);
        rd_reg(4'd4, d); check("R3 change register", d, 8'h23);
        rd_reg(4'd5, d); check("R6 summary cleared by read", d, 8'h00);
        // R5: falling edge on pin 0
        gp_in = 7'h02;
        tick(3);
        rd_reg(4'd4, d); check("R5 falling edge sets flag", d, 8'h12);
        // R8: full port
        gp_in = 7'h5A;
        tick(2);
        rd_reg(4'd13, d); check("R8 port read", d, 8'hDA);
        // R10: unmapped write and read
        wr_reg(4'd12, 8'hFF);
        rd_reg(4'd12, d); check("R10 unmapped read", d, 8'h00);
        chan_src = 7'h7F; #1;
        tick(2);
        check("R10 mask kept after stray write", {7'h0, irq}, 8'h00);
        // Mixed traffic compared against the model every cycle.
        for (int i = 0; i < 2000; i++) begin
            int op;
            chan_src = 7'($urandom);
            if (($urandom % 4) == 0) gp_in = gp_in ^ 7'(1 << ($urandom % 7));
            op = $urandom % 8;
            bus_rd = (op < 3);
            bus_wr = (op == 3 || op == 4);
            case ($urandom % 5)
                0: bus_addr = 4'd4;
                1: bus_addr = 4'd5;
                2: bus_addr = 4'd13;
                3: bus_addr = 4'd4;
                default: bus_addr = 4'($urandom);
            endcase
            bus_wdata = 8'($urandom);
            tick();
        end
        bus_rd = 1'b0; bus_wr = 1'b0;
        tick(2);
        finish_run();
    end

endmodule